// File: doc/BRIEF.md
# GPIO Port with Edge Interrupt Pending

An eight-pin general-purpose I/O port controlled through a small register bus. Each pin has a two-bit mode that makes it an input, a push-pull output, an open-drain output or, on the upper four pins, a push-pull output of a peripheral signal. Separate registers hold the output latch, the pull-up enables, the interrupt edge selection and the interrupt pending flags.

The three lowest pins can raise interrupts. Each pin input passes through a two-flop synchronizer, which feeds both the data read-back and the edge detectors. When a detected edge matches the edge selection of its pin, the pending flag of that pin sets itself. Software clears a flag by writing a zero to its bit. The active-low request line stays low while any flag is set.

Bus reads are combinational from the address. Bus writes take effect at the clock edge where the write strobe is high. Reset is asynchronous and active low.

Top module: `gpio_edge_port`

## Requirements
- R1: During and after reset, every pin output enable, pull-up enable and register read value is 0, and `irq_n` is 1.
- R2: A write to address F0h loads the output latch. A read of F0h returns the pin inputs delayed by two clock edges (two-flop synchronizer).
- R3: Pin mode 00 is an input (output enable 0). Mode 01 is push-pull: output enable 1, pin value equal to the latch bit.
- R4: Pin mode 10 is open-drain: latch bit 0 gives output enable 1 with value 0, and latch bit 1 gives output enable 0.
- R5: Mode 11 on pins 4 to 7 drives `alt_src[i-4]` push-pull. On pins 0 to 3, mode 11 behaves as an input.
- R6: The register at E8h holds the modes of pins 0 to 3, and the register at E9h holds the modes of pins 4 to 7. The mode of local pin j sits in bits [2j+1:2j]. Both registers read back as written.
- R7: The register at E6h drives `pin_pu` bit for bit and reads back as written.
- R8: The register at F9h holds the edge selection for interrupt pin k in bits [2k+1:2k]: 00 off, 01 falling, 10 rising, 11 both. Bits 7:6 read as 0. An unselected or disabled edge sets nothing.
- R9: A selected edge on pin k sets pending bit k in the register at F7h. The bit is visible at the third rising clock edge after the pin changes.
- R10: A write to F7h clears each pending bit whose write data bit is 0 and leaves bits written with 1 unchanged. Bits 7:3 read as 0.
- R11: If a selected edge and a clearing write hit the same bit in the same cycle, the bit stays set.
- R12: `irq_n` is 0 exactly while at least one pending bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data for bus_addr |
| pin_in | input | 8 | Sampled pin levels |
| pin_oe | output | 8 | Pin output enables |
| pin_out | output | 8 | Pin output values |
| pin_pu | output | 8 | Pull-up enables |
| alt_src | input | 4 | Peripheral outputs for pins 4 to 7 |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A wrong synchronizer or edge-history bit shows up in one of two ways. Either the pending flag sets one cycle early or late, or it sets on an edge that was not selected. In both cases `irq_n` and the F7h read-back diverge from the reference model at the cycle after the mis-detected edge. A corrupted mode or latch bit reaches `pin_oe` and `pin_out` combinationally, so the mismatch appears in the same cycle the register changes. A flaw in the clear logic is caught in the cycle after the write: a flag is dropped while an edge is arriving, or it survives a zero write.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   typedef enum logic [1:0] {
      PM_INPUT     = 2'b00,
      PM_PUSHPULL  = 2'b01,
      PM_OPENDRAIN = 2'b10,
      PM_ALTFN     = 2'b11
   } pin_mode_e;

   typedef enum logic [1:0] {
      EDGE_OFF  = 2'b00,
      EDGE_FALL = 2'b01,
      EDGE_RISE = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_sel_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
   import gpio_port_pkg::*;
#(
   parameter bit ALT_CAPABLE = 1'b0
) (
   input  logic [1:0] mode,
   input  logic       latch,
   input  logic       alt,
   output logic       oe,
   output logic       out
);
   always_comb begin
      oe  = 1'b0;
      out = 1'b0;
      case (pin_mode_e'(mode))
         PM_INPUT: begin
            oe  = 1'b0;
            out = 1'b0;
         end
         PM_PUSHPULL: begin
            oe  = 1'b1;
            out = latch;
         end
         PM_OPENDRAIN: begin
            oe  = ~latch;
            out = 1'b0;
         end
         PM_ALTFN: begin
            oe  = ALT_CAPABLE;
            out = ALT_CAPABLE ? alt : 1'b0;
         end
         default: begin
            oe  = 1'b0;
            out = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/gpio_irq_channel.sv
module gpio_irq_channel
   import gpio_port_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       level,
   input  logic [1:0] sel,
   input  logic       clr,
   output logic       hit,
   output logic       pend
);
   logic prev_q;
   logic rise, fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level;
   end

   assign rise = level & ~prev_q;
   assign fall = ~level & prev_q;

   always_comb begin
      case (edge_sel_e'(sel))
         EDGE_FALL: hit = fall;
         EDGE_RISE: hit = rise;
         EDGE_BOTH: hit = rise | fall;
         default:   hit = 1'b0;
      endcase
   end

   // a new edge overrides a same-cycle software clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pend <= 1'b0;
      else if (hit) pend <= 1'b1;
      else if (clr) pend <= 1'b0;
   end
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port #(
   parameter int          PINS         = 8,
   parameter int          IRQ_PINS     = 3,
   parameter int          ALT_PINS     = 4,
   parameter int          ADDR_W       = 8,
   parameter int          DATA_W       = 8,
   parameter int          SYNC_STAGES  = 2,
   parameter logic [7:0]  ADDR_DATA    = 8'hF0,
   parameter logic [7:0]  ADDR_MODE_LO = 8'hE8,
   parameter logic [7:0]  ADDR_MODE_HI = 8'hE9,
   parameter logic [7:0]  ADDR_PULL    = 8'hE6,
   parameter logic [7:0]  ADDR_ICTL    = 8'hF9,
   parameter logic [7:0]  ADDR_PEND    = 8'hF7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   input  logic                bus_wr,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [PINS-1:0]     pin_in,
   output logic [PINS-1:0]     pin_oe,
   output logic [PINS-1:0]     pin_out,
   output logic [PINS-1:0]     pin_pu,
   input  logic [ALT_PINS-1:0] alt_src,
   output logic                irq_n
);
   localparam int ALT_BASE  = PINS - ALT_PINS;
   localparam int ICTL_W    = 2 * IRQ_PINS;
   localparam int HALF_PINS = PINS / 2;

   if (PINS != DATA_W) begin : g_bad_width
      $error("PINS must equal DATA_W");
   end
   if (PINS % 2 != 0) begin : g_bad_half
      $error("PINS must be even");
   end
   if (ICTL_W > DATA_W || IRQ_PINS < 1) begin : g_bad_irq
      $error("IRQ_PINS out of range");
   end
   if (ALT_PINS > PINS || ALT_PINS < 1) begin : g_bad_alt
      $error("ALT_PINS out of range");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (ADDR_W != 8) begin : g_bad_addr
      $error("ADDR_W must be 8 for the address map");
   end

   logic [DATA_W-1:0]   data_q, mode_lo_q, mode_hi_q, pull_q;
   logic [ICTL_W-1:0]   ictl_q;
   logic [2*PINS-1:0]   mode_vec;
   logic [PINS-1:0]     pin_sync;
   logic [IRQ_PINS-1:0] pend_q, edge_hit, pend_clr;
   logic                wr_data, wr_lo, wr_hi, wr_pull, wr_ictl, wr_pend;

   assign wr_data = bus_wr && (bus_addr == ADDR_DATA);
   assign wr_lo   = bus_wr && (bus_addr == ADDR_MODE_LO);
   assign wr_hi   = bus_wr && (bus_addr == ADDR_MODE_HI);
   assign wr_pull = bus_wr && (bus_addr == ADDR_PULL);
   assign wr_ictl = bus_wr && (bus_addr == ADDR_ICTL);
   assign wr_pend = bus_wr && (bus_addr == ADDR_PEND);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q    <= '0;
         mode_lo_q <= '0;
         mode_hi_q <= '0;
         pull_q    <= '0;
         ictl_q    <= '0;
      end else begin
         if (wr_data) data_q    <= bus_wdata;
         if (wr_lo)   mode_lo_q <= bus_wdata;
         if (wr_hi)   mode_hi_q <= bus_wdata;
         if (wr_pull) pull_q    <= bus_wdata;
         if (wr_ictl) ictl_q    <= bus_wdata[ICTL_W-1:0];
      end
   end

   assign mode_vec = {mode_hi_q[2*HALF_PINS-1:0], mode_lo_q[2*HALF_PINS-1:0]};
   assign pin_pu   = pull_q;

   gpio_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_sync)
   );

   for (genvar i = 0; i < PINS; i++) begin : g_pin
      if (i >= ALT_BASE) begin : g_alt
         gpio_pin_ctrl #(.ALT_CAPABLE(1'b1)) u_pin (
            .mode  (mode_vec[2*i +: 2]),
            .latch (data_q[i]),
            .alt   (alt_src[i-ALT_BASE]),
            .oe    (pin_oe[i]),
            .out   (pin_out[i])
         );
      end else begin : g_plain
         gpio_pin_ctrl #(.ALT_CAPABLE(1'b0)) u_pin (
            .mode  (mode_vec[2*i +: 2]),
            .latch (data_q[i]),
            .alt   (1'b0),
            .oe    (pin_oe[i]),
            .out   (pin_out[i])
         );
      end
   end

   for (genvar k = 0; k < IRQ_PINS; k++) begin : g_irq
      assign pend_clr[k] = wr_pend && !bus_wdata[k];
      gpio_irq_channel u_chan (
         .clk   (clk),
         .rst_n (rst_n),
         .level (pin_sync[k]),
         .sel   (ictl_q[2*k +: 2]),
         .clr   (pend_clr[k]),
         .hit   (edge_hit[k]),
         .pend  (pend_q[k])
      );
   end

   assign irq_n = ~(|pend_q);

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_DATA)         bus_rdata = pin_sync;
      else if (bus_addr == ADDR_MODE_LO) bus_rdata = mode_lo_q;
      else if (bus_addr == ADDR_MODE_HI) bus_rdata = mode_hi_q;
      else if (bus_addr == ADDR_PULL)    bus_rdata = pull_q;
      else if (bus_addr == ADDR_ICTL)    bus_rdata[ICTL_W-1:0] = ictl_q;
      else if (bus_addr == ADDR_PEND)    bus_rdata[IRQ_PINS-1:0] = pend_q;
   end
endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk #(
   parameter int         PINS      = 8,
   parameter int         IRQ_PINS  = 3,
   parameter int         ADDR_W    = 8,
   parameter logic [7:0] ADDR_PEND = 8'hF7
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [IRQ_PINS-1:0] bus_wdata_lo,
   input logic                bus_wr,
   input logic [2*PINS-1:0]   modes,
   input logic [PINS-1:0]     pin_oe,
   input logic [2*IRQ_PINS-1:0] ictl,
   input logic [IRQ_PINS-1:0] hit,
   input logic [IRQ_PINS-1:0] pend,
   input logic                irq_n
);
   for (genvar i = 0; i < PINS; i++) begin : g_pin_chk
      // R3: input mode never drives the pin
      assert_input_undriven_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (modes[2*i +: 2] == 2'b00) |-> !pin_oe[i]);
   end

   for (genvar k = 0; k < IRQ_PINS; k++) begin : g_irq_chk
      assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (ictl[2*k +: 2] == 2'b00) |-> !hit[k]);
      assert_pend_needs_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pend[k]) |-> $past(hit[k]));
      assert_zero_write_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && bus_addr == ADDR_PEND && !bus_wdata_lo[k] && !hit[k]) |=> !pend[k]);
      assert_edge_beats_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
         hit[k] |=> pend[k]);
   end

   assert_irq_fall_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_n) |-> $past(|hit));
endmodule

bind gpio_edge_port gpio_edge_port_chk #(
   .PINS      (PINS),
   .IRQ_PINS  (IRQ_PINS),
   .ADDR_W    (ADDR_W),
   .ADDR_PEND (ADDR_PEND)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_addr     (bus_addr),
   .bus_wdata_lo (bus_wdata[IRQ_PINS-1:0]),
   .bus_wr       (bus_wr),
   .modes        (mode_vec),
   .pin_oe       (pin_oe),
   .ictl         (ictl_q),
   .hit          (edge_hit),
   .pend         (pend_q),
   .irq_n        (irq_n)
);

// File: tb/gpio_edge_port_test.sv
module gpio_edge_port_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = 8'h00;
   logic [7:0] bus_wdata = 8'h00;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_rdata;
   logic [7:0] pin_in = 8'h00;
   logic [7:0] pin_oe, pin_out, pin_pu;
   logic [3:0] alt_src = 4'h0;
   logic       irq_n;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   gpio_edge_port uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_wr    (bus_wr),
      .bus_rdata (bus_rdata),
      .pin_in    (pin_in),
      .pin_oe    (pin_oe),
      .pin_out   (pin_out),
      .pin_pu    (pin_pu),
      .alt_src   (alt_src),
      .irq_n     (irq_n)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model
   logic [7:0] m_data = 0, m_lo = 0, m_hi = 0, m_pull = 0, m_s1 = 0, m_s2 = 0;
   logic [5:0] m_ictl = 0;
   logic [2:0] m_pend = 0, m_prev = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_data = 0; m_lo = 0; m_hi = 0; m_pull = 0; m_s1 = 0; m_s2 = 0;
         m_ictl = 0; m_pend = 0; m_prev = 0;
      end else begin
         logic [2:0] hits;
         logic [2:0] np;
         for (int k = 0; k < 3; k++) begin
            logic cur, old;
            logic [1:0] sel;
            cur = m_s2[k]; old = m_prev[k]; sel = m_ictl[2*k +: 2];
            hits[k] = (sel[1] && cur && !old) || (sel[0] && !cur && old);
         end
         np = m_pend;
         if (bus_wr && bus_addr == 8'hF7) np = np & bus_wdata[2:0];
         np = np | hits;
         if (bus_wr) begin
            case (bus_addr)
               8'hF0: m_data = bus_wdata;
               8'hE8: m_lo   = bus_wdata;
               8'hE9: m_hi   = bus_wdata;
               8'hE6: m_pull = bus_wdata;
               8'hF9: m_ictl = bus_wdata[5:0];
               default: ;
            endcase
         end
         m_pend = np;
         m_prev = m_s2[2:0];
         m_s2 = m_s1;
         m_s1 = pin_in;
      end
      #5;
      begin
         logic [7:0] e_oe, e_out, e_rd;
         logic [15:0] mv;
         mv = {m_hi, m_lo};
         for (int i = 0; i < 8; i++) begin
            logic [1:0] m;
            m = mv[2*i +: 2];
            e_oe[i] = 0; e_out[i] = 0;
            if (m == 2'b01) begin e_oe[i] = 1; e_out[i] = m_data[i]; end
            else if (m == 2'b10) e_oe[i] = !m_data[i];
            else if (m == 2'b11 && i >= 4) begin e_oe[i] = 1; e_out[i] = alt_src[i-4]; end
         end
         case (bus_addr)
            8'hF0: e_rd = m_s2;
            8'hE8: e_rd = m_lo;
            8'hE9: e_rd = m_hi;
            8'hE6: e_rd = m_pull;
            8'hF9: e_rd = {2'b00, m_ictl};
            8'hF7: e_rd = {5'b0, m_pend};
            default: e_rd = 8'h00;
         endcase
         check("R3 model pin_oe", pin_oe, e_oe);
         check("R3 model pin_out", pin_out, e_out);
         check("R7 model pin_pu", pin_pu, m_pull);
         check("R12 model irq_n", irq_n, (m_pend == 0));
         check("R2 model bus_rdata", bus_rdata, e_rd);
      end
   end

   task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic wait_neg(input int n);
      for (int j = 0; j < n; j++) @(negedge clk);
   endtask

   initial begin
      #(20 * 100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] rd;
      wait_neg(2);
      bus_addr = 8'hE8;
      #1;
      check("R1 reset pin_oe", pin_oe, 0);
      check("R1 reset pin_pu", pin_pu, 0);
      check("R1 reset irq_n", irq_n, 1);
      check("R1 reset mode read", bus_rdata, 0);
      @(negedge clk) rst_n = 1'b1;

      // R6 / R3 push-pull on pin 1 and pin 7
      bus_write(8'hE8, 8'b00_00_01_00);
      bus_write(8'hF0, 8'h82);
      bus_write(8'hE9, 8'b01_00_00_00);
      @(negedge clk);
      check("R6 mode layout pin_oe", pin_oe, 8'h82);
      check("R3 push-pull pin_out", pin_out, 8'h82);
      bus_read(8'hE9, rd);
      check("R6 high mode readback", rd, 8'h40);

      // R4 open-drain on pin 0
      bus_write(8'hE8, 8'b00_00_01_10);
      @(negedge clk);
      check("R4 open-drain low drives", {pin_oe[0], pin_out[0]}, 2'b10);
      bus_write(8'hF0, 8'h83);
      @(negedge clk);
      check("R4 open-drain high releases", pin_oe[0], 0);

      // R5 alternate function
      bus_write(8'hE9, 8'b01_00_00_11);
      alt_src = 4'b0001;
      @(negedge clk);
      check("R5 alt pin4 oe", pin_oe[4], 1);
      check("R5 alt pin4 value", pin_out[4], 1);
      alt_src = 4'b0000;
      @(negedge clk);
      check("R5 alt pin4 follows", pin_out[4], 0);
      bus_write(8'hE8, 8'b11_00_01_10);
      @(negedge clk);
      check("R5 low pin mode 11 is input", pin_oe[3], 0);

      // R7 pull-ups
      bus_write(8'hE6, 8'hA5);
      @(negedge clk);
      check("R7 pull-up drive", pin_pu, 8'hA5);

      // R2 synchronized read of pins
      @(negedge clk);
      pin_in = 8'h3C;
      bus_addr = 8'hF0;
      @(negedge clk);
      check("R2 read before second edge", bus_rdata, 8'h00);
      @(negedge clk);
      check("R2 read after two edges", bus_rdata, 8'h3C);

      // R9 rising edge on pin 0, three-edge latency
      bus_write(8'hF9, 8'h02);
      @(negedge clk) pin_in[0] = 1'b1;
      wait_neg(2);
      check("R9 not yet pending", irq_n, 1);
      @(negedge clk);
      check("R9 pending at third edge", irq_n, 0);
      bus_read(8'hF7, rd);
      check("R9 pending bit", rd, 8'h01);
      bus_write(8'hF7, 8'h00);
      check("R10 zero write clears", irq_n, 1);

      // R8 unselected and disabled edges
      @(negedge clk);
      pin_in[0] = 1'b0;
      pin_in[1] = 1'b1;
      wait_neg(4);
      check("R8 ignored edges irq", irq_n, 1);
      bus_read(8'hF7, rd);
      check("R8 ignored edges pend", rd, 0);

      // R10 selective clear
      bus_write(8'hF9, 8'h12);
      @(negedge clk);
      pin_in[2] = 1'b0;
      pin_in[0] = 1'b1;
      wait_neg(3);
      bus_read(8'hF7, rd);
      check("R9 two pins pending", rd, 8'h05);
      bus_write(8'hF7, 8'hFE);
      bus_read(8'hF7, rd);
      check("R10 ones keep bits", rd, 8'h04);
      check("R12 irq with one left", irq_n, 0);
      bus_write(8'hF7, 8'hFB);
      bus_read(8'hF7, rd);
      check("R10 all cleared", rd, 8'h00);
      check("R12 irq released", irq_n, 1);
      bus_read(8'hF9, rd);
      check("R8 ictl readback", rd, 8'h12);
      bus_write(8'hF9, 8'hFF);
      bus_read(8'hF9, rd);
      check("R8 ictl upper bits zero", rd, 8'h3F);

      // R11 edge wins over clear; pin 0 on both edges
      bus_write(8'hF9, 8'h03);
      @(negedge clk) pin_in[0] = 1'b0;
      wait_neg(3);
      check("R9 falling in both mode", irq_n, 0);
      @(negedge clk) pin_in[0] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      bus_addr = 8'hF7; bus_wdata = 8'h00; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      #1;
      check("R11 edge beats clear", bus_rdata, 8'h01);
      check("R11 irq held", irq_n, 0);
      bus_write(8'hF7, 8'h00);
      bus_read(8'hF7, rd);
      check("R10 clear afterwards", rd, 8'h00);

      wait_neg(2);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule